// File: doc/BRIEF.md
# Serial Frame Byte-Delimiter Generator

This block watches a serial receive stream, one bit per rising edge of `clk`, counting only the edges on which `rx_en` is high. It hunts for the start-of-frame delimiter. The delimiter is a run of alternating preamble bits followed by two ones in a row. After it finds the delimiter, the block passes every following bit out on `ser_data`, qualified by `ser_valid`. Alongside the data it drives a byte-boundary strobe, so that an external address-match circuit can follow the frame bit by bit and find each byte.

The block also collects the first 48 frame bits as the destination address. It accepts the frame when that address equals the programmed station address or is all ones. The external `ext_reject` input is ORed into this decision, and the result appears as a one-cycle accept or reject pulse. While `tx_active` is high, the strobe is held low.

The delimiter hunter has three states:
- `DET_IDLE`: no bit seen yet.
- `DET_RUN`: tracking the length of the current alternating run.
- `DET_FRAME`: passing data through.

Its transitions are:
- `DET_IDLE` to `DET_RUN` on the first sampled bit.
- `DET_RUN` to `DET_FRAME` on a second consecutive one that ends a long enough run.
- Any state to `DET_IDLE` when `rx_en` is low.

The address filter also has three states:
- `FLT_IDLE`: waiting for the first frame bit.
- `FLT_COLLECT`: shifting in address bits.
- `FLT_DONE`: decision made, waiting for the frame to end.

Its transitions are:
- `FLT_IDLE` to `FLT_COLLECT` on the first frame bit.
- `FLT_COLLECT` to `FLT_DONE` on address bit 47.
- Any state to `FLT_IDLE` when no frame bit is sampled.

Top module: `sfd_strobe_top`

## Requirements
- R1: Bits are sampled only on rising edges of `clk` where `rx_en` is high. An edge with `rx_en` low ends any frame, re-arms the delimiter hunt, and drives `ser_valid`, `ser_data` and `byte_strobe` low after that edge.
- R2: A frame starts on the sampled edge of a one that follows another sampled one, provided the alternating run ending in the first of the two ones has at least PRE_MIN (default 8) bits. A repeated bit that does not meet this condition restarts the run count at 1. A short preamble therefore starts no frame.
- R3: Frame bit i (i = 0 is the first bit after the delimiter, the first destination-address bit) is shown on `ser_data` with `ser_valid` high after the edge that samples it. The delimiter's own ones are never marked valid.
- R4: `byte_strobe` is high while frame bits 8k to 8k+3 are shown and low while bits 8k+4 to 8k+7 are shown. It therefore rises together with the first bit of every byte and toggles every 4 bit times.
- R5: When `tx_active` is high at an edge, `byte_strobe` is low after that edge.
- R6: The destination address is frame bits 0 to 47. Bit i maps to `station_addr[i]`. The internal filter passes when the address equals `station_addr` or is all ones.
- R7: A frame is rejected if the filter fails or if `ext_reject` is high at the edge that samples bit 47. With `ext_reject` held low, only the filter decides.
- R8: After the edge that samples bit 47, exactly one of `frame_accept` or `frame_reject` pulses for one cycle. There is at most one decision per frame, none for a frame shorter than 48 bits, and the two are never high together.
- R9: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive data qualifier |
| rx_bit | input | 1 | Serial receive data |
| tx_active | input | 1 | High while a frame is being transmitted |
| ext_reject | input | 1 | External reject, ORed into the decision; tie low if unused |
| station_addr | input | 48 | Programmed station address, bit 0 matched first |
| ser_data | output | 1 | Frame bit passed through |
| ser_valid | output | 1 | High while `ser_data` carries a frame bit |
| byte_strobe | output | 1 | Byte-boundary strobe |
| frame_accept | output | 1 | One-cycle accept pulse |
| frame_reject | output | 1 | One-cycle reject pulse |

## Verification
The in-module assertions check the cycle-local rules on every edge:
- the strobe is low after a transmit-active edge and after an `rx_en`-low edge;
- accept and reject never coincide, and a decision pulse lasts exactly one cycle;
- an accept never follows an asserted external reject;
- a frame never starts without two sampled ones;
- the strobe rises only together with valid data.

The bench's scenarios cover the sequence-dependent behaviour:
- the required preamble length before the delimiter;
- the 4-on, 4-off strobe pattern lined up with byte starts;
- address matching for station, broadcast and foreign addresses;
- the bit index at which the decision appears;
- recovery after `rx_en` drops in the middle of a frame.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [1:0] {
        DET_IDLE  = 2'd0,
        DET_RUN   = 2'd1,
        DET_FRAME = 2'd2
    } det_state_t;

    typedef enum logic [1:0] {
        FLT_IDLE    = 2'd0,
        FLT_COLLECT = 2'd1,
        FLT_DONE    = 2'd2
    } flt_state_t;

endpackage

// File: rtl/sfd_hunt.sv
module sfd_hunt
    import sfd_pkg::*;
#(
    parameter int PRE_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic rx_bit,
    output logic in_frame
);
    localparam int RUN_W = $clog2(PRE_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PRE_MIN);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    det_state_t state_q, state_d;
    logic             last_q;
    logic [RUN_W-1:0] run_q, run_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            DET_IDLE: begin
                if (rx_en) begin
                    state_d = DET_RUN;
                    run_d   = RUN_ONE;
                end
            end
            DET_RUN: begin
                if (!rx_en) begin
                    state_d = DET_IDLE;
                end else if (rx_bit == last_q) begin
                    if (rx_bit && run_q >= RUN_MAX) begin
                        state_d = DET_FRAME;
                    end else begin
                        run_d = RUN_ONE;
                    end
                end else if (run_q < RUN_MAX) begin
                    run_d = run_q + RUN_ONE;
                end
            end
            DET_FRAME: begin
                if (!rx_en) begin
                    state_d = DET_IDLE;
                end
            end
            default: state_d = DET_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
            run_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            if (rx_en) begin
                last_q <= rx_bit;
            end
        end
    end

    // outputs
    always_comb begin
        in_frame = (state_q == DET_FRAME);
    end

    // R2
    frame_needs_two_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> ($past(rx_en) && $past(rx_bit) && $past(last_q)));

    // R1
    frame_ends_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !in_frame);

endmodule

// File: rtl/sfd_strobe_gen.sv
module sfd_strobe_gen #(
    parameter int BYTE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_sample,
    input  logic rx_bit,
    input  logic tx_active,
    output logic ser_data,
    output logic ser_valid,
    output logic byte_strobe
);
    localparam int HALF  = BYTE_BITS / 2;
    localparam int PH_W  = $clog2(BYTE_BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_BITS - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

    logic [PH_W-1:0] phase_q;
    logic            strobe_d;

    always_comb begin
        strobe_d = data_sample && !tx_active && (phase_q < PH_HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            ser_data    <= 1'b0;
            ser_valid   <= 1'b0;
            byte_strobe <= 1'b0;
        end else if (data_sample) begin
            phase_q     <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
            ser_data    <= rx_bit;
            ser_valid   <= 1'b1;
            byte_strobe <= strobe_d;
        end else begin
            phase_q     <= '0;
            ser_data    <= 1'b0;
            ser_valid   <= 1'b0;
            byte_strobe <= 1'b0;
        end
    end

    // R5
    strobe_quiet_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !byte_strobe);

    // R4
    strobe_rise_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_strobe) |-> ser_valid);

    // R1
    outputs_clear_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_sample |=> (!ser_valid && !byte_strobe));

endmodule

// File: rtl/sfd_addr_filter.sv
module sfd_addr_filter
    import sfd_pkg::*;
#(
    parameter int ADDR_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_sample,
    input  logic                 rx_bit,
    input  logic                 ext_reject,
    input  logic [ADDR_BITS-1:0] station_addr,
    output logic                 frame_accept,
    output logic                 frame_reject
);
    localparam int CNT_W = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BITS - 1);

    flt_state_t state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_BITS-1:0] addr_q, addr_d;
    logic                 last_bit, hit;

    always_comb begin
        addr_d   = {rx_bit, addr_q[ADDR_BITS-1:1]};
        last_bit = (cnt_q == CNT_LAST);
        hit      = (addr_d == station_addr) || (&addr_d);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!data_sample) begin
            state_d = FLT_IDLE;
        end else begin
            unique case (state_q)
                FLT_IDLE:    state_d = FLT_COLLECT;
                FLT_COLLECT: state_d = last_bit ? FLT_DONE : FLT_COLLECT;
                FLT_DONE:    state_d = FLT_DONE;
                default:     state_d = FLT_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!data_sample) begin
                cnt_q <= '0;
            end else if (state_q != FLT_DONE) begin
                addr_q <= addr_d;
                if (!last_bit) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_accept <= 1'b0;
            frame_reject <= 1'b0;
        end else begin
            frame_accept <= 1'b0;
            frame_reject <= 1'b0;
            if (data_sample && state_q != FLT_DONE && last_bit) begin
                frame_accept <= hit && !ext_reject;
                frame_reject <= !hit || ext_reject;
            end
        end
    end

    // R8
    decision_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_accept && frame_reject));

    // R8
    decision_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_accept || frame_reject) |=> !(frame_accept || frame_reject));

    // R7
    ext_reject_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_accept |-> !$past(ext_reject));

endmodule

// File: rtl/sfd_strobe_top.sv
module sfd_strobe_top #(
    parameter int PRE_MIN   = 8,
    parameter int BYTE_BITS = 8,
    parameter int ADDR_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 rx_bit,
    input  logic                 tx_active,
    input  logic                 ext_reject,
    input  logic [ADDR_BITS-1:0] station_addr,
    output logic                 ser_data,
    output logic                 ser_valid,
    output logic                 byte_strobe,
    output logic                 frame_accept,
    output logic                 frame_reject
);
    logic in_frame;
    logic data_sample;

    always_comb begin
        data_sample = rx_en && in_frame;
    end

    sfd_hunt #(.PRE_MIN(PRE_MIN)) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .rx_bit   (rx_bit),
        .in_frame (in_frame)
    );

    sfd_strobe_gen #(.BYTE_BITS(BYTE_BITS)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_sample (data_sample),
        .rx_bit      (rx_bit),
        .tx_active   (tx_active),
        .ser_data    (ser_data),
        .ser_valid   (ser_valid),
        .byte_strobe (byte_strobe)
    );

    sfd_addr_filter #(.ADDR_BITS(ADDR_BITS)) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_sample  (data_sample),
        .rx_bit       (rx_bit),
        .ext_reject   (ext_reject),
        .station_addr (station_addr),
        .frame_accept (frame_accept),
        .frame_reject (frame_reject)
    );

    // R8
    no_decision_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_accept || frame_reject) |-> $past(data_sample));

endmodule

// File: tb/tb_sfd_strobe_top.sv
module tb_sfd_strobe_top;
    localparam logic [47:0] STATION = 48'h0123_4567_89AB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rx_bit = 1'b0, tx_active = 1'b0, ext_reject = 1'b0;
    logic ser_data, ser_valid, byte_strobe, frame_accept, frame_reject;

    always #10 clk = ~clk;

    sfd_strobe_top dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .tx_active(tx_active), .ext_reject(ext_reject), .station_addr(STATION),
        .ser_data(ser_data), .ser_valid(ser_valid), .byte_strobe(byte_strobe),
        .frame_accept(frame_accept), .frame_reject(frame_reject)
    );

    typedef struct packed { logic v; logic d; logic s; logic a; logic r; } obs_t;
    obs_t  exp_q[$];
    string tag_q[$];
    int compared = 0, mismatched = 0;
    int acc_seen = 0, rej_seen = 0;

    // reference model state
    int          m_state = 0;
    logic        m_last = 1'b0;
    int          m_run = 0;
    int          m_n = 0;
    logic [47:0] m_da = '0;

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: apply one bit time and push the expected outcome
    task automatic step(input logic en, input logic b, input logic tx, input logic ext, input string tag);
        obs_t e;
        @(negedge clk);
        rx_en = en; rx_bit = b; tx_active = tx; ext_reject = ext;
        e = '0;
        if (!en) begin
            m_state = 0;
        end else if (m_state == 0) begin
            m_state = 1; m_last = b; m_run = 1;
        end else if (m_state == 1) begin
            if (b == m_last) begin
                if (b && m_run >= 8) begin
                    m_state = 2; m_n = 0;
                end else begin
                    m_run = 1;
                end
            end else if (m_run < 8) begin
                m_run++;
            end
            m_last = b;
        end else begin
            e.v = 1'b1;
            e.d = b;
            e.s = ((m_n % 8) < 4) && !tx;
            if (m_n < 48) m_da[m_n] = b;
            if (m_n == 47) begin
                e.a = ((m_da == STATION) || (&m_da)) && !ext;
                e.r = !e.a;
            end
            m_n++;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: pop and compare after each edge
    initial begin
        obs_t  e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (frame_accept === 1'b1) acc_seen++;
            if (frame_reject === 1'b1) rej_seen++;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_bit({"R3 ", t}, "ser_valid",    ser_valid,    e.v);
                check_bit({"R3 ", t}, "ser_data",     ser_data,     e.d);
                check_bit({"R4 ", t}, "byte_strobe",  byte_strobe,  e.s);
                check_bit({"R8 ", t}, "frame_accept", frame_accept, e.a);
                check_bit({"R8 ", t}, "frame_reject", frame_reject, e.r);
            end
        end
    end

    task automatic send_frame(input int pre_len, input logic [47:0] da, input int data_len,
                              input logic ext, input logic tx, input string tag);
        for (int i = 0; i < pre_len; i++) step(1'b1, (i % 2) == 0, 1'b0, ext, tag);
        step(1'b1, 1'b1, 1'b0, ext, tag);
        step(1'b1, 1'b1, 1'b0, ext, tag);
        for (int i = 0; i < data_len; i++)
            step(1'b1, (i < 48) ? da[i] : ((i % 3) == 0), tx, ext, tag);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    task automatic drain;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int a0, r0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check_bit("R9", "ser_valid",    ser_valid,    1'b0);
        check_bit("R9", "byte_strobe",  byte_strobe,  1'b0);
        check_bit("R9", "frame_accept", frame_accept, 1'b0);
        check_bit("R9", "frame_reject", frame_reject, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R9");

        // R6 station match
        a0 = acc_seen; r0 = rej_seen;
        send_frame(14, STATION, 64, 1'b0, 1'b0, "R6"); drain();
        check_int("R6", "accepts after station frame", acc_seen - a0, 1);
        check_int("R8", "decisions per frame", (acc_seen - a0) + (rej_seen - r0), 1);

        // R6 broadcast
        a0 = acc_seen;
        send_frame(10, '1, 56, 1'b0, 1'b0, "R6"); drain();
        check_int("R6", "accepts after broadcast", acc_seen - a0, 1);

        // R6 foreign address
        r0 = rej_seen;
        send_frame(16, 48'hFEDC_BA98_7654, 50, 1'b0, 1'b0, "R6"); drain();
        check_int("R6", "rejects after foreign frame", rej_seen - r0, 1);

        // R7 external reject overrides a match
        r0 = rej_seen; a0 = acc_seen;
        send_frame(12, STATION, 52, 1'b1, 1'b0, "R7"); drain();
        check_int("R7", "rejects with ext_reject", rej_seen - r0, 1);
        check_int("R7", "accepts with ext_reject", acc_seen - a0, 0);

        // R5 strobe held low while transmitting
        send_frame(12, STATION, 40, 1'b0, 1'b1, "R5"); drain();

        // R2 short preamble starts nothing
        a0 = acc_seen; r0 = rej_seen;
        send_frame(2, '0, 60, 1'b0, 1'b0, "R2"); drain();
        check_int("R2", "decisions after short preamble", (acc_seen - a0) + (rej_seen - r0), 0);

        // R1 rx_en drop mid-frame, then recovery; R8 no decision on short frame
        a0 = acc_seen; r0 = rej_seen;
        send_frame(12, STATION, 20, 1'b0, 1'b0, "R1"); drain();
        check_int("R8", "decisions on 20-bit frame", (acc_seen - a0) + (rej_seen - r0), 0);
        send_frame(8, STATION, 70, 1'b0, 1'b0, "R4"); drain();
        check_int("R1", "accept after re-arm", acc_seen - a0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule